// File: doc/BRIEF.md
# GPIO Input Debounce Filter

This block removes contact bounce and short noise pulses from one general-purpose input pin. It runs from a slow real-time clock (nominally 32.768 kHz) and takes a pin level that has already been synchronized into that clock domain. It produces a filtered level that feeds the pin status and interrupt logic.

A prescaler divides the clock into ticks of one of four lengths, chosen by two unit-select bits. A 4-bit count sets how many ticks a new level must be held before it is accepted. Four modes are available:

- pass the pin straight through with no filtering;
- filter changes in both directions;
- filter only rising changes, so a falling change passes at once;
- filter only falling changes, so a rising change passes at once.

A ready output tells the interrupt logic when it may be armed. It goes high once the filter has run for its warm-up time after its last configuration change.

Top module: `gpio_debounce_filter`

## Requirements
- R1: When `cfg_mode` = 2'b00, `pin_filt` equals `pin_raw` in the same cycle, with no register in the path, and `ready` is 1.
- R2: When `cfg_mode` = 2'b01, `pin_filt` takes on a new `pin_raw` level only after `pin_raw` has differed from `pin_filt` for N×U consecutive clock edges. The output updates on the N×U-th such edge. N is the tick count and U is the tick length in clocks.
- R3: In the filtering modes, if `pin_raw` returns to the current `pin_filt` level before the delay has run out, the prescaler and tick counter are cleared. The full delay then starts again from zero.
- R4: `{cfg_large, cfg_unit}` selects the tick length U: 2'b00 gives UNIT_A, 2'b01 gives UNIT_B, 2'b10 gives UNIT_C and 2'b11 gives UNIT_D clocks. The defaults are 2, 8, 512 and 2048.
- R5: The tick count N equals `cfg_count`, except that a `cfg_count` of 0 gives N = 1.
- R6: When `cfg_mode` = 2'b10, a falling `pin_raw` is passed to `pin_filt` one clock edge later. A rising `pin_raw` is filtered as in R2.
- R7: When `cfg_mode` = 2'b11, a rising `pin_raw` is passed to `pin_filt` one clock edge later. A falling `pin_raw` is filtered as in R2.
- R8: A change to any configuration input is seen on the next clock edge. On that edge the prescaler and tick counter are cleared, so a delay in progress starts again under the new settings.
- R9: In a filtering mode, `ready` is 0 from a configuration change until WARM_CLKS clock edges after the edge that detected the change. It is 1 from then on. The default WARM_CLKS of 30 is about 900 µs at 32.768 kHz.
- R10: While `rst_n` is low, the filtered level register is 0 and the counters are clear. With the configuration inputs all 0 and `pin_raw` at 0, this gives `pin_filt` = 0 and `ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Real-time clock |
| rst_n | input | 1 | Active-low reset |
| cfg_mode | input | 2 | 00 bypass, 01 filter both, 10 filter rises only, 11 filter falls only |
| cfg_count | input | 4 | Debounce length in ticks (0 is treated as 1) |
| cfg_large | input | 1 | Upper tick-unit select bit |
| cfg_unit | input | 1 | Lower tick-unit select bit |
| pin_raw | input | 1 | Synchronized pin level |
| pin_filt | output | 1 | Filtered pin level |
| ready | output | 1 | Warm-up complete, interrupts may be armed |

## Verification
The bench builds the block with tick lengths of 2, 4, 8 and 16 clocks and a warm-up of 7 clocks instead of the defaults. With these values every unit select, a 32-clock worst case and the warm-up edge can each be reached in tens of cycles. The same expected-cycle arithmetic as for the default values can still be checked exactly. With these settings the bench covers a glitch that reverses mid-count, a configuration change in the middle of a count, a count of zero, and both one-sided modes in both directions.

// File: rtl/gpio_debounce_filter.sv
module gpio_debounce_filter #(
  parameter int UNIT_A    = 2,
  parameter int UNIT_B    = 8,
  parameter int UNIT_C    = 512,
  parameter int UNIT_D    = 2048,
  parameter int WARM_CLKS = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_mode,
  input  logic [3:0] cfg_count,
  input  logic       cfg_large,
  input  logic       cfg_unit,
  input  logic       pin_raw,
  output logic       pin_filt,
  output logic       ready
);
  localparam int MAX_AB = (UNIT_A > UNIT_B) ? UNIT_A : UNIT_B;
  localparam int MAX_CD = (UNIT_C > UNIT_D) ? UNIT_C : UNIT_D;
  localparam int MAXU   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int PW     = (MAXU > 2) ? $clog2(MAXU) : 1;
  localparam int WW     = $clog2(WARM_CLKS + 1);
  localparam logic [1:0] M_BYPASS = 2'b00;
  localparam logic [1:0] M_BOTH   = 2'b01;
  localparam logic [1:0] M_RISE   = 2'b10;
  localparam logic [1:0] M_FALL   = 2'b11;

  logic [7:0]    cfg_q;
  logic [PW-1:0] pre_q, pre_lim;
  logic [3:0]    tick_q, tick_lim;
  logic [WW-1:0] warm_q;
  logic          filt_q;

  wire [7:0] cfg_now = {cfg_mode, cfg_count, cfg_large, cfg_unit};
  wire chg  = cfg_now != cfg_q;
  wire mism = pin_raw != filt_q;
  wire fast = (cfg_mode == M_RISE && !pin_raw) || (cfg_mode == M_FALL && pin_raw);

  always_comb begin
    case ({cfg_large, cfg_unit})
      2'b00:   pre_lim = PW'(UNIT_A - 1);
      2'b01:   pre_lim = PW'(UNIT_B - 1);
      2'b10:   pre_lim = PW'(UNIT_C - 1);
      default: pre_lim = PW'(UNIT_D - 1);
    endcase
  end

  assign tick_lim = (cfg_count == 4'd0) ? 4'd0 : cfg_count - 4'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      warm_q <= '0;
    end else begin
      cfg_q <= cfg_now;
      if (chg) warm_q <= '0;
      else if (warm_q != WW'(WARM_CLKS)) warm_q <= warm_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      pre_q  <= '0;
      tick_q <= '0;
    end else if (cfg_mode == M_BYPASS || fast) begin
      filt_q <= pin_raw;
      pre_q  <= '0;
      tick_q <= '0;
    end else if (chg || !mism) begin
      pre_q  <= '0;
      tick_q <= '0;
    end else if (pre_q == pre_lim) begin
      pre_q <= '0;
      if (tick_q == tick_lim) begin
        filt_q <= pin_raw;
        tick_q <= '0;
      end else begin
        tick_q <= tick_q + 4'd1;
      end
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assign pin_filt = (cfg_mode == M_BYPASS) ? pin_raw : filt_q;
  assign ready    = (cfg_mode == M_BYPASS) || (warm_q == WW'(WARM_CLKS));

  // R2 R3
  glitch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_mode) == M_BOTH && filt_q != $past(filt_q))
      |-> ($past(pin_raw) == filt_q && $past(pin_raw, 2) == filt_q));

  // R6
  low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_mode) == M_RISE && !$past(pin_raw)) |-> !filt_q);

  // R7
  high_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_mode) == M_FALL && $past(pin_raw)) |-> filt_q);

  // R9
  warm_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> (!ready || cfg_mode == M_BYPASS));

  // R9
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> (chg || $past(chg)));
endmodule

// File: tb/gpio_debounce_filter_tb.sv
module gpio_debounce_filter_tb;
  localparam int W = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic [3:0] cfg_count = 4'd0;
  logic cfg_large = 1'b0, cfg_unit = 1'b0, pin_raw = 1'b0;
  logic pin_filt, ready;

  gpio_debounce_filter #(.UNIT_A(2), .UNIT_B(4), .UNIT_C(8), .UNIT_D(16), .WARM_CLKS(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_count(cfg_count),
    .cfg_large(cfg_large), .cfg_unit(cfg_unit), .pin_raw(pin_raw),
    .pin_filt(pin_filt), .ready(ready));

  always #2.5 clk = ~clk;

  typedef struct { int cyc; bit sel; bit val; string tag; } exp_t;
  exp_t q[$];
  int cyc = 0, total = 0, bad = 0;
  bit fv = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      bit got;
      e = q.pop_front();
      got = e.sel ? ready : pin_filt;
      total++;
      if (e.cyc != cyc || got != e.val) begin
        bad++;
        $display("FAIL %s: %s got %0b exp %0b (cycle %0d, due %0d)",
                 e.tag, e.sel ? "ready" : "pin_filt", got, e.val, cyc, e.cyc);
      end
    end
  end

  task automatic push(int c, bit s, bit v, string tag);
    exp_t e;
    e.cyc = c; e.sel = s; e.val = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drain();
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
  endtask

  task automatic set_cfg(bit [1:0] m, bit [3:0] n, bit lg, bit un, string tag);
    int k;
    @(posedge clk); #1;
    cfg_mode = m; cfg_count = n; cfg_large = lg; cfg_unit = un;
    k = cyc;
    if (m != 2'b00) begin
      push(k + W, 1'b1, 1'b0, tag);
      push(k + W + 1, 1'b1, 1'b1, tag);
    end else begin
      push(k, 1'b1, 1'b1, tag);
    end
    drain();
  endtask

  task automatic step_raw(bit v, int d, string tag);
    int k;
    @(posedge clk); #1;
    pin_raw = v;
    k = cyc;
    if (d == 0) push(k, 1'b0, v, tag);
    else begin
      push(k + d - 1, 1'b0, fv, tag);
      push(k + d, 1'b0, v, tag);
    end
    fv = v;
    drain();
  endtask

  initial begin
    int k;
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (pin_filt !== 1'b0 || ready !== 1'b1) begin
      bad++;
      $display("FAIL R10: filt=%0b ready=%0b exp 0 1", pin_filt, ready);
    end
    rst_n = 1'b1;

    set_cfg(2'b00, 4'd0, 1'b0, 1'b0, "R1");
    step_raw(1'b1, 0, "R1");
    step_raw(1'b0, 0, "R1");

    set_cfg(2'b01, 4'd3, 1'b0, 1'b0, "R9");
    step_raw(1'b1, 6, "R2");
    step_raw(1'b0, 6, "R2");

    // R3: reversal after 3 clocks, output must hold
    @(posedge clk); #1;
    pin_raw = 1'b1; k = cyc;
    repeat (3) @(posedge clk);
    #1; pin_raw = 1'b0;
    push(k + 10, 1'b0, 1'b0, "R3");
    drain();
    step_raw(1'b1, 6, "R3");

    set_cfg(2'b01, 4'd0, 1'b0, 1'b0, "R5");
    step_raw(1'b0, 2, "R5");

    set_cfg(2'b01, 4'd2, 1'b0, 1'b1, "R4");
    step_raw(1'b1, 8, "R4");
    set_cfg(2'b01, 4'd1, 1'b1, 1'b0, "R4");
    step_raw(1'b0, 8, "R4");
    set_cfg(2'b01, 4'd2, 1'b1, 1'b1, "R4");
    step_raw(1'b1, 32, "R4");

    // R8: config change mid-count restarts the delay under the new setting
    set_cfg(2'b01, 4'd3, 1'b0, 1'b0, "R9");
    @(posedge clk); #1;
    pin_raw = 1'b0; k = cyc;
    repeat (3) @(posedge clk);
    #1; cfg_count = 4'd4;
    push(k + 11, 1'b0, 1'b1, "R8");
    push(k + 12, 1'b0, 1'b0, "R8");
    drain();
    fv = 1'b0;

    set_cfg(2'b10, 4'd2, 1'b0, 1'b0, "R9");
    step_raw(1'b1, 4, "R6");
    step_raw(1'b0, 1, "R6");

    set_cfg(2'b11, 4'd2, 1'b0, 1'b0, "R9");
    step_raw(1'b1, 1, "R7");
    step_raw(1'b0, 4, "R7");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule